// File: doc/BRIEF.md
# SD Host Interrupt Status and Mask Registers

This block gathers the interrupt sources of an SD host controller into two 16-bit status words. Each word has its own 16-bit mask word. The command, data and buffer logic send single-cycle event pulses, and the block latches each one into a sticky flag. Card-detect arrives as a raw pin level. It passes through a two-flop synchroniser, and its edges become insert and remove flags. The live card-detect level, the DAT0 level and the command-busy level appear as plain readable bits in the same words as the sticky flags.

Software reads the four words through a small register port. It acknowledges a flag by writing 0 to that bit, and a 1 leaves the bit alone. The two buffer-ready flags react only to a rising edge of their buffer condition. If software clears such a flag while the buffer condition is still high, the flag stays clear until the condition falls and rises again. A single interrupt line is raised while any sticky flag is set and unmasked. After reset every source is masked.

Top module: `sdh_irq_regs`

## Requirements
- R1: While reset is asserted and immediately after it, every sticky flag reads 0, both mask words read 16'hFFFF and `irq` is 0.
- R2: A one-cycle pulse on an event input sets its flag at the next rising clock edge, and the flag then holds. Word 1 uses bit 0 for response done and bit 2 for data done. Word 2 uses bit 0 for index error, bit 1 for CRC error, bit 2 for end-bit error, bit 3 for data timeout, bit 4 for illegal write, bit 5 for illegal read, bit 6 for response timeout and bit 15 for illegal access.
- R3: A register write to a status word clears each sticky flag whose write-data bit is 0. Sticky flags whose write-data bit is 1 keep their value.
- R4: If an event pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R5: Word 2 bit 8 (read buffer ready) and bit 9 (write buffer ready) are set one cycle after their level input goes from 0 to 1. If software clears one of them while its level stays high, it stays 0.
- R6: Word 1 bit 5 shows the card-detect input two clock edges after the input changes. Bit 4 (inserted) is set one edge after bit 5 rises, and bit 3 (removed) is set one edge after bit 5 falls. A card that is present at reset release therefore reports an insertion.
- R7: Word 2 bit 14 shows the command-busy input and bit 7 shows the DAT0 input, both without delay. Writes to these bits, and to word 1 bit 5, have no effect. Bits that have no source read 0.
- R8: Both mask words can be read and written in full. `irq` is 1 exactly when some sticky flag is set and its mask bit is 0, counting the state after the last clock edge.
- R9: `reg_addr` selects the word: 0 is status word 1, 1 is status word 2, 2 is mask word 1 and 3 is mask word 2. `reg_rdata` is combinational from the address and the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Word select |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected word |
| ev_resp_done | input | 1 | Response completed pulse |
| ev_data_done | input | 1 | Data transfer completed pulse |
| ev_idx_err | input | 1 | Command index error pulse |
| ev_crc_err | input | 1 | CRC error pulse |
| ev_endbit_err | input | 1 | End-bit error pulse |
| ev_data_tmo | input | 1 | Data timeout pulse |
| ev_ill_wr | input | 1 | Illegal write pulse |
| ev_ill_rd | input | 1 | Illegal read pulse |
| ev_resp_tmo | input | 1 | Response timeout pulse |
| ev_ill_access | input | 1 | Illegal access pulse |
| rbuf_ready_lvl | input | 1 | Read buffer holds data (level) |
| wbuf_ready_lvl | input | 1 | Write buffer has room (level) |
| card_det_raw | input | 1 | Asynchronous card-detect pin level |
| dat0_lvl | input | 1 | DAT0 line level |
| cmd_busy_lvl | input | 1 | Command engine busy level |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench targets several corner cases, and each has a distinct symptom when the design gets it wrong. When an event and a clear reach the same flag in the same cycle, the flag must stay set. A design that gives priority to the clear loses that event. A buffer flag that is cleared while its level is still high must stay clear. A design that sets the flag from the level raises it again at once. Card-detect changes are checked against the exact two-edge synchroniser delay and the edge that follows it. Writes of 1 and of 0 go to the live bit positions, and the readback must not move. The unmasked interrupt line is checked on every cycle, so a design that inverts the mask sense or includes live bits in the interrupt shows up on the first mismatch.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;

   typedef enum logic [1:0] {
      A_STAT1 = 2'd0,
      A_STAT2 = 2'd1,
      A_MASK1 = 2'd2,
      A_MASK2 = 2'd3
   } sdh_reg_e;

   // status word 1 bit positions
   localparam int S1_RESP   = 0;
   localparam int S1_DATA   = 2;
   localparam int S1_REMOVE = 3;
   localparam int S1_INSERT = 4;
   localparam int S1_CDLVL  = 5;

   // status word 2 bit positions
   localparam int S2_IDX    = 0;
   localparam int S2_CRC    = 1;
   localparam int S2_ENDBIT = 2;
   localparam int S2_DTMO   = 3;
   localparam int S2_ILLWR  = 4;
   localparam int S2_ILLRD  = 5;
   localparam int S2_RTMO   = 6;
   localparam int S2_DAT0   = 7;
   localparam int S2_RBUF   = 8;
   localparam int S2_WBUF   = 9;
   localparam int S2_BUSY   = 14;
   localparam int S2_ILLACC = 15;

   localparam logic [15:0] S1_STICKY = 16'h001D;
   localparam logic [15:0] S2_STICKY = 16'h837F;

endpackage

// File: rtl/sdh_cd_sync.sv
module sdh_cd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sdh_cd_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], raw_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign lvl_o  = chain_q[STAGES-1];
   assign rise_o =  lvl_o & ~prev_q;
   assign fall_o = ~lvl_o &  prev_q;
endmodule

// File: rtl/sdh_edge_rise.sv
module sdh_edge_rise #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] rise_o
);
   if (N < 1) begin : g_bad_n
      $error("sdh_edge_rise: N must be positive");
   end

   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/sdh_stat_bank.sv
module sdh_stat_bank #(
   parameter int             W        = 16,
   parameter logic [W-1:0]   STICKY   = '0,
   parameter logic [W-1:0]   MASK_RST = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] src_i,     // pulse for sticky bits, level otherwise
   input  logic         stat_we,
   input  logic         mask_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] stat_o,
   output logic [W-1:0] mask_o,
   output logic         irq_o
);
   if (W < 1) begin : g_bad_w
      $error("sdh_stat_bank: W must be positive");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (STICKY[b]) begin : g_sticky
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        flag_q <= 1'b0;
            else if (src_i[b])                 flag_q <= 1'b1;
            else if (stat_we && !wdata[b])     flag_q <= 1'b0;
         end
         assign stat_o[b] = flag_q;
      end else begin : g_pass
         assign stat_o[b] = src_i[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_o <= MASK_RST;
      else if (mask_we) mask_o <= wdata;
   end

   assign irq_o = |(stat_o & STICKY & ~mask_o);
endmodule

// File: rtl/sdh_irq_regs.sv
module sdh_irq_regs #(
   parameter int REG_W     = 16,
   parameter int CD_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       reg_addr,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             ev_resp_done,
   input  logic             ev_data_done,
   input  logic             ev_idx_err,
   input  logic             ev_crc_err,
   input  logic             ev_endbit_err,
   input  logic             ev_data_tmo,
   input  logic             ev_ill_wr,
   input  logic             ev_ill_rd,
   input  logic             ev_resp_tmo,
   input  logic             ev_ill_access,
   input  logic             rbuf_ready_lvl,
   input  logic             wbuf_ready_lvl,
   input  logic             card_det_raw,
   input  logic             dat0_lvl,
   input  logic             cmd_busy_lvl,
   output logic             irq
);
   import sdh_irq_pkg::*;

   if (REG_W != 16) begin : g_bad_width
      $error("sdh_irq_regs: bit map requires REG_W of 16");
   end

   localparam logic [REG_W-1:0] STICKY1 = REG_W'(S1_STICKY);
   localparam logic [REG_W-1:0] STICKY2 = REG_W'(S2_STICKY);

   logic             cd_lvl, cd_rise, cd_fall;
   logic [1:0]       buf_rise;
   logic [REG_W-1:0] src1, src2;
   logic [REG_W-1:0] stat1_w, stat2_w, mask1_w, mask2_w;
   logic             irq1, irq2;

   sdh_cd_sync #(.STAGES(CD_STAGES)) u_cd (
      .clk(clk), .rst_n(rst_n), .raw_i(card_det_raw),
      .lvl_o(cd_lvl), .rise_o(cd_rise), .fall_o(cd_fall)
   );

   sdh_edge_rise #(.N(2)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .lvl_i({wbuf_ready_lvl, rbuf_ready_lvl}),
      .rise_o(buf_rise)
   );

   always_comb begin
      src1            = '0;
      src1[S1_RESP]   = ev_resp_done;
      src1[S1_DATA]   = ev_data_done;
      src1[S1_REMOVE] = cd_fall;
      src1[S1_INSERT] = cd_rise;
      src1[S1_CDLVL]  = cd_lvl;

      src2            = '0;
      src2[S2_IDX]    = ev_idx_err;
      src2[S2_CRC]    = ev_crc_err;
      src2[S2_ENDBIT] = ev_endbit_err;
      src2[S2_DTMO]   = ev_data_tmo;
      src2[S2_ILLWR]  = ev_ill_wr;
      src2[S2_ILLRD]  = ev_ill_rd;
      src2[S2_RTMO]   = ev_resp_tmo;
      src2[S2_DAT0]   = dat0_lvl;
      src2[S2_RBUF]   = buf_rise[0];
      src2[S2_WBUF]   = buf_rise[1];
      src2[S2_BUSY]   = cmd_busy_lvl;
      src2[S2_ILLACC] = ev_ill_access;
   end

   sdh_stat_bank #(.W(REG_W), .STICKY(STICKY1), .MASK_RST('1)) u_bank1 (
      .clk(clk), .rst_n(rst_n), .src_i(src1),
      .stat_we(reg_wr && reg_addr == A_STAT1),
      .mask_we(reg_wr && reg_addr == A_MASK1),
      .wdata(reg_wdata), .stat_o(stat1_w), .mask_o(mask1_w), .irq_o(irq1)
   );

   sdh_stat_bank #(.W(REG_W), .STICKY(STICKY2), .MASK_RST('1)) u_bank2 (
      .clk(clk), .rst_n(rst_n), .src_i(src2),
      .stat_we(reg_wr && reg_addr == A_STAT2),
      .mask_we(reg_wr && reg_addr == A_MASK2),
      .wdata(reg_wdata), .stat_o(stat2_w), .mask_o(mask2_w), .irq_o(irq2)
   );

   always_comb begin
      unique case (reg_addr)
         A_STAT1: reg_rdata = stat1_w;
         A_STAT2: reg_rdata = stat2_w;
         A_MASK1: reg_rdata = mask1_w;
         default: reg_rdata = mask2_w;
      endcase
   end

   assign irq = irq1 | irq2;
endmodule

// File: rtl/sdh_irq_chk.sv
module sdh_irq_chk #(
   parameter int REG_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       reg_addr,
   input logic             reg_wr,
   input logic [REG_W-1:0] reg_wdata,
   input logic             ev_resp_done,
   input logic             ev_data_done,
   input logic [REG_W-1:0] stat1_w,
   input logic [REG_W-1:0] mask1_w,
   input logic [REG_W-1:0] mask2_w,
   input logic             irq
);
   // R1: first cycle out of reset shows masks at all ones
   p_mask_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (mask1_w == '1 && mask2_w == '1));

   // R2: a response-done pulse sets word 1 bit 0
   p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_resp_done |=> stat1_w[0]);

   // R3: clear without a competing event drops the flag
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd0 && !reg_wdata[2] && !ev_data_done) |=> !stat1_w[2]);

   // R3: a flag not written to 0 stays set
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat1_w[2] && !(reg_wr && reg_addr == 2'd0 && !reg_wdata[2])) |=> stat1_w[2]);

   // R4: event beats a simultaneous clear
   p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd0 && !reg_wdata[0] && ev_resp_done) |=> stat1_w[0]);

   // R6: a rise of the synchronised card level reports an insertion
   p_insert_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat1_w[5]) |=> stat1_w[4]);

   // R8: with every source masked the line stays low
   p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mask1_w == '1 && mask2_w == '1) |-> !irq);
endmodule

bind sdh_irq_regs sdh_irq_chk #(.REG_W(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
   .reg_wdata(reg_wdata), .ev_resp_done(ev_resp_done),
   .ev_data_done(ev_data_done), .stat1_w(stat1_w), .mask1_w(mask1_w),
   .mask2_w(mask2_w), .irq(irq)
);

// File: tb/sdh_irq_regs_tb.sv
module sdh_irq_regs_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;
   logic ev_resp_done = 0, ev_data_done = 0, ev_idx_err = 0, ev_crc_err = 0;
   logic ev_endbit_err = 0, ev_data_tmo = 0, ev_ill_wr = 0, ev_ill_rd = 0;
   logic ev_resp_tmo = 0, ev_ill_access = 0;
   logic rbuf_ready_lvl = 0, wbuf_ready_lvl = 0, card_det_raw = 0;
   logic dat0_lvl = 0, cmd_busy_lvl = 0;
   logic irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdh_irq_regs u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ev_resp_done(ev_resp_done), .ev_data_done(ev_data_done),
      .ev_idx_err(ev_idx_err), .ev_crc_err(ev_crc_err),
      .ev_endbit_err(ev_endbit_err), .ev_data_tmo(ev_data_tmo),
      .ev_ill_wr(ev_ill_wr), .ev_ill_rd(ev_ill_rd),
      .ev_resp_tmo(ev_resp_tmo), .ev_ill_access(ev_ill_access),
      .rbuf_ready_lvl(rbuf_ready_lvl), .wbuf_ready_lvl(wbuf_ready_lvl),
      .card_det_raw(card_det_raw), .dat0_lvl(dat0_lvl),
      .cmd_busy_lvl(cmd_busy_lvl), .irq(irq)
   );

   // reference model state
   logic [15:0] m_s1 = 16'h0, m_s2 = 16'h0, m_k1 = 16'hFFFF, m_k2 = 16'hFFFF;
   logic [15:0] e1, e2;
   int          cd_pipe [3];
   int          rb_prev = 0, wb_prev = 0;
   int          checks = 0, fails = 0;
   bit          done = 0;
   string       cur_req = "R1";

   initial for (int i = 0; i < 3; i++) cd_pipe[i] = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_k1 = 16'hFFFF; m_k2 = 16'hFFFF;
         for (int i = 0; i < 3; i++) cd_pipe[i] = 0;
         rb_prev = 0; wb_prev = 0;
      end else begin
         e1 = 0; e2 = 0;
         e1[0] = ev_resp_done; e1[2] = ev_data_done;
         e1[4] = (cd_pipe[1] == 1) && (cd_pipe[2] == 0);
         e1[3] = (cd_pipe[1] == 0) && (cd_pipe[2] == 1);
         e2[0] = ev_idx_err; e2[1] = ev_crc_err; e2[2] = ev_endbit_err;
         e2[3] = ev_data_tmo; e2[4] = ev_ill_wr; e2[5] = ev_ill_rd;
         e2[6] = ev_resp_tmo; e2[15] = ev_ill_access;
         e2[8] = rbuf_ready_lvl && (rb_prev == 0);
         e2[9] = wbuf_ready_lvl && (wb_prev == 0);
         if (reg_wr) begin
            case (reg_addr)
               2'd0: m_s1 = m_s1 & reg_wdata;
               2'd1: m_s2 = m_s2 & reg_wdata;
               2'd2: m_k1 = reg_wdata;
               default: m_k2 = reg_wdata;
            endcase
         end
         m_s1 = (m_s1 | e1) & 16'h001D;
         m_s2 = (m_s2 | e2) & 16'h837F;
         cd_pipe[2] = cd_pipe[1];
         cd_pipe[1] = cd_pipe[0];
         cd_pipe[0] = card_det_raw ? 1 : 0;
         rb_prev = rbuf_ready_lvl ? 1 : 0;
         wb_prev = wbuf_ready_lvl ? 1 : 0;
      end
   end

   function automatic logic [15:0] exp_read(input logic [1:0] a);
      logic [15:0] v;
      case (a)
         2'd0: begin v = m_s1; v[5] = (cd_pipe[1] == 1); end
         2'd1: begin v = m_s2; v[14] = cmd_busy_lvl; v[7] = dat0_lvl; end
         2'd2: v = m_k1;
         default: v = m_k2;
      endcase
      return v;
   endfunction

   task automatic compare();
      logic exp_irq;
      exp_irq = |(m_s1 & ~m_k1) | |(m_s2 & ~m_k2);
      checks++;
      if (reg_rdata !== exp_read(reg_addr)) begin
         fails++;
         $display("FAIL %s rdata addr %0d act %h exp %h", cur_req, reg_addr,
                  reg_rdata, exp_read(reg_addr));
      end
      checks++;
      if (irq !== exp_irq) begin
         fails++;
         $display("FAIL %s irq act %0b exp %0b", cur_req, irq, exp_irq);
      end
   endtask

   // advance one cycle, compare at the falling edge
   task automatic tick();
      @(negedge clk);
      compare();
   endtask

   // read all four words with no other stimulus
   task automatic sweep();
      for (int a = 0; a < 4; a++) begin
         reg_addr = a[1:0];
         #1 compare();
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic clear_events();
      ev_resp_done = 0; ev_data_done = 0; ev_idx_err = 0; ev_crc_err = 0;
      ev_endbit_err = 0; ev_data_tmo = 0; ev_ill_wr = 0; ev_ill_rd = 0;
      ev_resp_tmo = 0; ev_ill_access = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R9 watchdog act running exp finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      cur_req = "R1";
      repeat (3) tick();
      sweep();
      rst_n = 1'b1;
      tick();
      sweep();

      // R2 every event pulse
      cur_req = "R2";
      ev_resp_done = 1; ev_idx_err = 1; ev_data_tmo = 1; ev_ill_access = 1;
      tick(); clear_events();
      tick(); sweep();
      ev_data_done = 1; ev_crc_err = 1; ev_endbit_err = 1; ev_ill_wr = 1;
      ev_ill_rd = 1; ev_resp_tmo = 1;
      tick(); clear_events();
      tick(); sweep();

      // R3 write-zero clear, write-one keep
      cur_req = "R3";
      wr(2'd0, 16'hFFFE);
      sweep();
      wr(2'd1, 16'hFF0F);
      sweep();

      // R4 simultaneous event and clear
      cur_req = "R4";
      ev_resp_done = 1; ev_crc_err = 1;
      wr(2'd0, 16'h0000);
      clear_events();
      tick(); sweep();
      ev_crc_err = 1;
      wr(2'd1, 16'h0000);
      clear_events();
      tick(); sweep();

      // R5 buffer-ready edge behaviour
      cur_req = "R5";
      rbuf_ready_lvl = 1;
      tick(); tick(); sweep();
      wr(2'd1, 16'hFEFF);
      repeat (4) tick();
      sweep();
      rbuf_ready_lvl = 0; tick();
      rbuf_ready_lvl = 1; wbuf_ready_lvl = 1; tick(); tick();
      sweep();

      // R6 card detect synchronisation and edges
      cur_req = "R6";
      wr(2'd0, 16'h0000);
      card_det_raw = 1;
      for (int i = 0; i < 5; i++) begin tick(); reg_addr = 2'd0; #1 compare(); end
      card_det_raw = 0;
      for (int i = 0; i < 5; i++) begin tick(); reg_addr = 2'd0; #1 compare(); end

      // R7 live bits and ignored writes
      cur_req = "R7";
      cmd_busy_lvl = 1; dat0_lvl = 1; card_det_raw = 1;
      reg_addr = 2'd1; #1 compare();
      wr(2'd1, 16'hBF7F);
      wr(2'd1, 16'hFFFF);
      repeat (3) tick();
      wr(2'd0, 16'hFFDF);
      sweep();
      cmd_busy_lvl = 0; dat0_lvl = 0;
      reg_addr = 2'd1; #1 compare();

      // R8 masking and interrupt line
      cur_req = "R8";
      wr(2'd2, 16'hFFFB);
      sweep();
      ev_data_done = 1; tick(); clear_events();
      tick(); sweep();
      wr(2'd2, 16'hFFFF);
      sweep();
      wr(2'd3, 16'h7FFF);
      ev_ill_access = 1; tick(); clear_events();
      tick(); sweep();
      wr(2'd1, 16'h7FFF);
      sweep();
      wr(2'd3, 16'hA5C3);
      sweep();

      // R9 randomised traffic on the whole map
      cur_req = "R9";
      for (int n = 0; n < 3000; n++) begin
         ev_resp_done  = ($urandom % 8) == 0;
         ev_data_done  = ($urandom % 8) == 0;
         ev_idx_err    = ($urandom % 12) == 0;
         ev_crc_err    = ($urandom % 12) == 0;
         ev_endbit_err = ($urandom % 12) == 0;
         ev_data_tmo   = ($urandom % 12) == 0;
         ev_ill_wr     = ($urandom % 12) == 0;
         ev_ill_rd     = ($urandom % 12) == 0;
         ev_resp_tmo   = ($urandom % 12) == 0;
         ev_ill_access = ($urandom % 12) == 0;
         if (($urandom % 6) == 0) rbuf_ready_lvl = ~rbuf_ready_lvl;
         if (($urandom % 6) == 0) wbuf_ready_lvl = ~wbuf_ready_lvl;
         if (($urandom % 10) == 0) card_det_raw = ~card_det_raw;
         if (($urandom % 5) == 0) dat0_lvl = ~dat0_lvl;
         if (($urandom % 5) == 0) cmd_busy_lvl = ~cmd_busy_lvl;
         reg_addr  = 2'($urandom % 4);
         reg_wr    = ($urandom % 4) == 0;
         reg_wdata = 16'($urandom);
         tick();
      end
      clear_events();
      reg_wr = 1'b0;
      tick();
      sweep();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule